// File: doc/BRIEF.md
# Escape Opcode Dispatch and Trap

This block sits at the front of a byte-code stack machine and classifies each incoming instruction. Most instructions are one byte long. Two prefix bytes, 0xF8 and 0xF9, mark an escape: the byte after the prefix is an operand whose upper nibble picks a group of sixteen operations and whose lower nibble picks the entry inside that group. For every complete instruction the block produces either a handler select or an opcode trap.

The escape decode runs in two steps. A 16-bit group-enable parameter says which groups exist at all. A 256-bit map parameter, one bit per escape operand, says which entries inside an enabled group are implemented. An operand that misses either step traps with code 0x100 plus the operand and a rewound PC that points at the prefix. A fixed set of unimplemented single-byte opcodes traps with the opcode itself as the code. While a trap is on the outputs, the block stalls its input for that cycle so the following byte waits instead of being lost.

Top module: `esc_dispatch`

## Requirements
- R1: After reset hnd_valid and trap_valid are 0, in_ready is 1, and the first accepted byte is decoded as a single-byte opcode.
- R2: A single-byte opcode that is neither a prefix nor unimplemented gives, in the cycle after it is accepted, a one-cycle hnd_valid with hnd_esc=0 and {hnd_group,hnd_index} equal to the byte.
- R3: The single-byte opcodes 0x3E, 0x3F, 0x7D, 0x7E, 0x7F, 0xBF and 0xFA to 0xFE give, in the cycle after acceptance, a one-cycle trap_valid with trap_code equal to the byte (bit 8 clear) and trap_pc equal to that byte's in_pc.
- R4: An accepted prefix byte 0xF8 or 0xF9 outside an escape produces neither output, and the next accepted byte is taken as the escape operand.
- R5: An escape operand in an enabled group whose map bit (bit index = operand value) is set gives a one-cycle hnd_valid with hnd_esc=1, hnd_group = operand[7:4] and hnd_index = operand[3:0].
- R6: An escape operand whose group bit in GROUPS_ON (default 0x0187: groups 0, 1, 2, 7, 8) is clear traps even when its map bits are set.
- R7: An escape operand in an enabled group whose map bit is clear traps; with the default map, group 0 entries 0 and 1, group 2 entries 12 to 15, group 7 entry 15 and group 8 entries 2 to 15 are clear.
- R8: An escape trap carries trap_code = 0x100 + operand.
- R9: An escape trap carries trap_pc = (operand in_pc + 1) - 2, the address of the prefix when the two bytes are adjacent.
- R10: In the cycle trap_valid is high, in_ready is 0, and a byte held on the input is accepted in the following cycle and decoded normally.
- R11: hnd_valid and trap_valid are never high together, and each is a single-cycle pulse per instruction.
- R12: Both prefixes behave identically, and a prefix value received as an operand is decoded as an operand (group 15), not as a new prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_pc | input | PC_W | Address of in_byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| hnd_valid | output | 1 | One-cycle handler select pulse |
| hnd_esc | output | 1 | Handler is an escape operation |
| hnd_group | output | 4 | Group nibble (upper opcode nibble for single bytes) |
| hnd_index | output | 4 | Index nibble (lower opcode nibble for single bytes) |
| trap_valid | output | 1 | One-cycle opcode trap pulse |
| trap_code | output | 9 | Trap parameter |
| trap_pc | output | PC_W | Restart address of the trapping instruction |

## Verification
The bench aims at the seams of the two-step escape lookup: an operand in a disabled group whose map row is deliberately filled with ones, where a design that skipped the group gate would emit a handler, and the edge entries of enabled groups (0x00, 0x01, 0x2B against 0x2C, 0x7E against 0x7F, 0x81 against 0x82). It checks the 0x100 offset and the rewound PC, where an off-by-one or a lost bit 8 shows up directly in trap_code or trap_pc. It holds a byte on the input across a trap; a design that ignored the stall would drop that byte or decode it during the trap. It also feeds a prefix value as an operand, which a design that re-armed the escape state would swallow silently.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int N_GROUPS = 1 << NIB_W;
    localparam int N_ENTRY  = 1 << NIB_W;
    localparam int MAP_W    = N_GROUPS * N_ENTRY;
    localparam int TCODE_W  = BYTE_W + 1;

    localparam logic [BYTE_W-1:0] PREFIX_A = 8'hF8;
    localparam logic [BYTE_W-1:0] PREFIX_B = 8'hF9;

    typedef enum logic [1:0] {
        DK_NONE    = 2'd0,
        DK_HANDLER = 2'd1,
        DK_TRAP    = 2'd2
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e          kind;
        logic               esc;
        logic [NIB_W-1:0]   grp;
        logic [NIB_W-1:0]   idx;
        logic [TCODE_W-1:0] tcode;
    } dec_res_t;

    function automatic logic is_prefix(input logic [BYTE_W-1:0] b);
        return (b == PREFIX_A) || (b == PREFIX_B);
    endfunction

    function automatic logic single_unimpl(input logic [BYTE_W-1:0] b);
        logic hit;
        case (b)
            8'h3E, 8'h3F,
            8'h7D, 8'h7E, 8'h7F,
            8'hBF,
            8'hFA, 8'hFB, 8'hFC, 8'hFD, 8'hFE: hit = 1'b1;
            default:                           hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/esc_seq.sv
module esc_seq
    import esc_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              esc_mode,
    output logic              fire
);
    logic pending_q;
    logic arm;

    // a prefix only arms the escape when no escape is already pending
    assign arm      = accept && !pending_q && is_prefix(byte_in);
    assign fire     = accept && !arm;
    assign esc_mode = pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (accept) begin
            pending_q <= arm;
        end
    end
endmodule

// File: rtl/esc_classify.sv
module esc_classify
    import esc_dec_pkg::*;
#(
    parameter int                 PC_W      = 16,
    parameter logic [N_GROUPS-1:0] GROUPS_ON = 16'h0187,
    parameter logic [MAP_W-1:0]   IMPL_MAP  = 256'h0
)(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              esc_mode,
    input  logic [PC_W-1:0]   pc_in,
    output dec_res_t          res,
    output logic [PC_W-1:0]   trap_pc
);
    // stage one gates whole groups, stage two picks the entry bit
    logic [N_ENTRY-1:0] row [N_GROUPS];

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_row
        if (GROUPS_ON[g]) begin : g_on
            assign row[g] = IMPL_MAP[g*N_ENTRY +: N_ENTRY];
        end else begin : g_off
            assign row[g] = '0;
        end
    end

    logic [NIB_W-1:0] hi_nib, lo_nib;
    logic             esc_hit;

    assign hi_nib  = byte_in[BYTE_W-1:NIB_W];
    assign lo_nib  = byte_in[NIB_W-1:0];
    assign esc_hit = row[hi_nib][lo_nib];

    always_comb begin
        res.esc   = esc_mode;
        res.grp   = hi_nib;
        res.idx   = lo_nib;
        res.tcode = '0;
        trap_pc   = pc_in;
        if (esc_mode) begin
            if (esc_hit) begin
                res.kind = DK_HANDLER;
            end else begin
                res.kind  = DK_TRAP;
                res.tcode = TCODE_W'(9'h0FF) + TCODE_W'(byte_in) + TCODE_W'(1);
                // step past the operand, then back over operand and prefix
                trap_pc   = (pc_in + PC_W'(1)) - PC_W'(2);
            end
        end else if (single_unimpl(byte_in)) begin
            res.kind  = DK_TRAP;
            res.tcode = TCODE_W'(byte_in);
        end else begin
            res.kind = DK_HANDLER;
        end
    end
endmodule

// File: rtl/esc_outreg.sv
module esc_outreg
    import esc_dec_pkg::*;
#(
    parameter int PC_W = 16
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  dec_res_t           res,
    input  logic [PC_W-1:0]    tpc,
    output logic               hnd_valid,
    output logic               hnd_esc,
    output logic [NIB_W-1:0]   hnd_group,
    output logic [NIB_W-1:0]   hnd_index,
    output logic               trap_valid,
    output logic [TCODE_W-1:0] trap_code,
    output logic [PC_W-1:0]    trap_pc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hnd_valid  <= 1'b0;
            hnd_esc    <= 1'b0;
            hnd_group  <= '0;
            hnd_index  <= '0;
            trap_valid <= 1'b0;
            trap_code  <= '0;
            trap_pc    <= '0;
        end else begin
            hnd_valid  <= fire && (res.kind == DK_HANDLER);
            trap_valid <= fire && (res.kind == DK_TRAP);
            if (fire && res.kind == DK_HANDLER) begin
                hnd_esc   <= res.esc;
                hnd_group <= res.grp;
                hnd_index <= res.idx;
            end
            if (fire && res.kind == DK_TRAP) begin
                trap_code <= res.tcode;
                trap_pc   <= tpc;
            end
        end
    end
endmodule

// File: rtl/esc_dispatch.sv
module esc_dispatch
    import esc_dec_pkg::*;
#(
    parameter int                  PC_W      = 16,
    parameter logic [N_GROUPS-1:0] GROUPS_ON = 16'h0187,
    parameter logic [MAP_W-1:0]    IMPL_MAP  = {112'h0, 16'h0003, 16'h7FFF,
                                                64'h0, 16'h0FFF, 16'hFFFF, 16'hFFFC}
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    input  logic [PC_W-1:0] in_pc,
    output logic            in_ready,
    output logic            hnd_valid,
    output logic            hnd_esc,
    output logic [3:0]      hnd_group,
    output logic [3:0]      hnd_index,
    output logic            trap_valid,
    output logic [8:0]      trap_code,
    output logic [PC_W-1:0] trap_pc
);
    logic            accept, esc_mode, fire;
    dec_res_t        res;
    logic [PC_W-1:0] tpc;

    // stall for the cycle a trap is presented
    assign in_ready = !trap_valid;
    assign accept   = in_valid && in_ready;

    esc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .byte_in  (in_byte),
        .esc_mode (esc_mode),
        .fire     (fire)
    );

    esc_classify #(
        .PC_W      (PC_W),
        .GROUPS_ON (GROUPS_ON),
        .IMPL_MAP  (IMPL_MAP)
    ) u_cls (
        .byte_in  (in_byte),
        .esc_mode (esc_mode),
        .pc_in    (in_pc),
        .res      (res),
        .trap_pc  (tpc)
    );

    esc_outreg #(.PC_W(PC_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .res        (res),
        .tpc        (tpc),
        .hnd_valid  (hnd_valid),
        .hnd_esc    (hnd_esc),
        .hnd_group  (hnd_group),
        .hnd_index  (hnd_index),
        .trap_valid (trap_valid),
        .trap_code  (trap_code),
        .trap_pc    (trap_pc)
    );
endmodule

// File: rtl/esc_dispatch_chk.sv
module esc_dispatch_chk #(
    parameter int          PC_W      = 16,
    parameter logic [15:0] GROUPS_ON = 16'h0187
)(
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] in_pc,
    input logic            in_ready,
    input logic            hnd_valid,
    input logic            hnd_esc,
    input logic [3:0]      hnd_group,
    input logic            trap_valid,
    input logic [8:0]      trap_code,
    input logic [PC_W-1:0] trap_pc
);
    // R11
    excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(hnd_valid && trap_valid));

    // R10
    stall_on_trap_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> !in_ready);

    // R11
    trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> !trap_valid);

    // R9
    esc_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && trap_code[8]) |-> (trap_pc == $past(in_pc) - PC_W'(1)));

    // R3
    single_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_valid && !trap_code[8]) |-> (trap_pc == $past(in_pc)));

    // R6
    group_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (hnd_valid && hnd_esc) |-> GROUPS_ON[hnd_group]);
endmodule

bind esc_dispatch esc_dispatch_chk #(.PC_W(PC_W), .GROUPS_ON(GROUPS_ON)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_pc      (in_pc),
    .in_ready   (in_ready),
    .hnd_valid  (hnd_valid),
    .hnd_esc    (hnd_esc),
    .hnd_group  (hnd_group),
    .trap_valid (trap_valid),
    .trap_code  (trap_code),
    .trap_pc    (trap_pc)
);

// File: tb/sim_esc_dispatch.sv
`timescale 1ns/1ps
module sim_esc_dispatch;
    localparam int PC_W = 16;
    // groups 3 and 9 filled with ones to prove the group gate
    localparam logic [255:0] MAP = {96'h0, 16'hFFFF, 16'h0003, 16'h7FFF,
                                    48'h0, 16'hFFFF, 16'h0FFF, 16'hFFFF, 16'hFFFC};

    logic            clk = 0, rst = 1;
    logic            in_valid = 0;
    logic [7:0]      in_byte = 0;
    logic [PC_W-1:0] in_pc = 0;
    logic            in_ready, hnd_valid, hnd_esc, trap_valid;
    logic [3:0]      hnd_group, hnd_index;
    logic [8:0]      trap_code;
    logic [PC_W-1:0] trap_pc;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    esc_dispatch #(.PC_W(PC_W), .IMPL_MAP(MAP)) u0 (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one byte, wait for acceptance, return at the negedge after it
    task automatic send(input logic [7:0] b, input logic [PC_W-1:0] pc);
        @(negedge clk);
        in_valid = 1; in_byte = b; in_pc = pc;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic exp_hnd(input bit esc, input logic [7:0] code, input string tag);
        check(hnd_valid == 1 && trap_valid == 0, {tag, " valid"}, {hnd_valid, trap_valid}, 2);
        check(hnd_esc == esc, {tag, " esc"}, hnd_esc, esc);
        check({hnd_group, hnd_index} == code, {tag, " code"}, {hnd_group, hnd_index}, code);
        @(negedge clk);
        check(hnd_valid == 0, {tag, " pulse R11"}, hnd_valid, 0);
    endtask

    task automatic exp_trap(input logic [8:0] code, input logic [PC_W-1:0] pc, input string tag);
        check(trap_valid == 1 && hnd_valid == 0, {tag, " valid"}, {trap_valid, hnd_valid}, 2);
        check(trap_code == code, {tag, " code"}, trap_code, code);
        check(trap_pc == pc, {tag, " pc"}, trap_pc, pc);
        check(in_ready == 0, {tag, " stall R10"}, in_ready, 0);
        @(negedge clk);
        check(trap_valid == 0, {tag, " pulse R11"}, trap_valid, 0);
    endtask

    task automatic exp_none(input string tag);
        check(hnd_valid == 0 && trap_valid == 0, tag, {hnd_valid, trap_valid}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(in_ready == 1, "R1 ready", in_ready, 1);
        exp_none("R1 idle");
        send(8'h30, 16'h0100);
        exp_hnd(1'b0, 8'h30, "R1 first byte single");
    endtask

    task automatic t_single();
        send(8'h05, 16'h0200); exp_hnd(1'b0, 8'h05, "R2 05");
        send(8'hFF, 16'h0201); exp_hnd(1'b0, 8'hFF, "R2 FF");
        send(8'h3D, 16'h0202); exp_hnd(1'b0, 8'h3D, "R2 3D");
        send(8'h3E, 16'h0203); exp_trap(9'h03E, 16'h0203, "R3 3E");
        send(8'h7F, 16'h0204); exp_trap(9'h07F, 16'h0204, "R3 7F");
        send(8'hBF, 16'h0205); exp_trap(9'h0BF, 16'h0205, "R3 BF");
        send(8'hFA, 16'h0206); exp_trap(9'h0FA, 16'h0206, "R3 FA");
        send(8'hFE, 16'h0207); exp_trap(9'h0FE, 16'h0207, "R3 FE");
    endtask

    task automatic t_escape();
        send(8'hF8, 16'h0300); exp_none("R4 prefix silent");
        send(8'h12, 16'h0301); exp_hnd(1'b1, 8'h12, "R5 12");
        send(8'hF9, 16'h0310); exp_none("R12 prefix B silent");
        send(8'h2B, 16'h0311); exp_hnd(1'b1, 8'h2B, "R5 R12 2B");
        send(8'hF8, 16'h0320); send(8'h81, 16'h0321); exp_hnd(1'b1, 8'h81, "R5 81");
        send(8'hF8, 16'h0330); send(8'h7E, 16'h0331); exp_hnd(1'b1, 8'h7E, "R5 7E");
    endtask

    task automatic t_esc_trap();
        send(8'hF8, 16'h0400); send(8'h35, 16'h0401); exp_trap(9'h135, 16'h0400, "R6 R8 R9 35");
        send(8'hF9, 16'h0410); send(8'h90, 16'h0411); exp_trap(9'h190, 16'h0410, "R6 90");
        send(8'hF8, 16'h0420); send(8'h00, 16'h0421); exp_trap(9'h100, 16'h0420, "R7 00");
        send(8'hF8, 16'h0430); send(8'h01, 16'h0431); exp_trap(9'h101, 16'h0430, "R7 01");
        send(8'hF8, 16'h0440); send(8'h2C, 16'h0441); exp_trap(9'h12C, 16'h0440, "R7 2C");
        send(8'hF8, 16'h0450); send(8'h7F, 16'h0451); exp_trap(9'h17F, 16'h0450, "R7 7F");
        send(8'hF8, 16'h0460); send(8'h82, 16'h0461); exp_trap(9'h182, 16'h0460, "R7 82");
        send(8'hF9, 16'h0470); send(8'hF8, 16'h0471); exp_trap(9'h1F8, 16'h0470, "R12 prefix as operand");
        send(8'h05, 16'h0480); exp_hnd(1'b0, 8'h05, "R12 back to single");
        send(8'hF8, 16'hFFFF); send(8'h00, 16'h0000); exp_trap(9'h100, 16'hFFFF, "R9 wrap");
    endtask

    task automatic t_holdoff();
        @(negedge clk);
        in_valid = 1; in_byte = 8'h3F; in_pc = 16'h0500;
        @(negedge clk);
        check(trap_valid == 1 && trap_code == 9'h03F, "R10 trap seen", trap_code, 9'h03F);
        check(in_ready == 0, "R10 stalled", in_ready, 0);
        in_byte = 8'h44; in_pc = 16'h0501;
        @(negedge clk);
        exp_none("R10 held byte waits");
        check(in_ready == 1, "R10 ready again", in_ready, 1);
        @(negedge clk);
        in_valid = 0;
        exp_hnd(1'b0, 8'h44, "R10 held byte decoded");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_single();
        t_escape();
        t_esc_trap();
        t_holdoff();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule